// File: doc/BRIEF.md
# ATM Cell Symbol-Delineating Receiver

This block sits behind a parallel line receiver that delivers one 9-bit word per clock when `line_valid` is high. Bit 8 of the word separates data octets from line symbols. A separate violation flag, read together with bit 8, marks words that the line receiver could not decode. The block finds cell boundaries from an explicit start-of-cell command symbol and does not hunt on the header check. After that symbol it collects 53 data octets and streams them out with start and end markers, one cycle after each octet arrives.

While hunting, the block drops sync commands, other commands and stray data. Violation words never enter a cell and never advance the octet position. A saturating 16-bit counter counts them, and a synchronous clear input resets it. If a command arrives partway through a cell, the cell is abandoned. No end marker is sent for it, and a one-cycle error pulse tells the consumer to discard the octets it has already taken.

Top module: `cell_delineator`

## Requirements
- R1: A word is taken only when `line_valid` is 1. With bit 8 = 0 it is a data octet carried in bits 7:0, whatever the violation flag is. With bit 8 = 1 and `line_viol` = 1 it is a violation. With bit 8 = 1 and `line_viol` = 0 it is a command whose code is in bits 7:0. The start-of-cell code is 0xC5 and the sync code is 0x71.
- R2: While hunting, data words, sync commands and every command other than start-of-cell produce no output (`cell_valid` stays 0).
- R3: After a start-of-cell command, each of the next 53 data octets appears on `cell_data` with `cell_valid` = 1 in the cycle after it is accepted.
- R4: A violation word produces no output and does not advance the octet position within the cell.
- R5: Each violation word raises `viol_count` by one in the following cycle, whether the block is hunting or collecting.
- R6: `cell_sop` is 1 on the first octet of a cell and `cell_eop` is 1 on the 53rd. After the 53rd octet the block hunts again, so further data is not output.
- R7: A command that arrives after at least one octet of a cell has been accepted raises `cell_err` for one cycle with no output and no `cell_eop`. If that command is start-of-cell, a new cell begins. Any other command returns the block to hunting.
- R8: `viol_count` saturates at 0xFFFF.
- R9: `viol_clr` = 1 makes `viol_count` 0 in the next cycle and takes priority over a violation in the same cycle.
- R10: After reset the block is hunting, all cell outputs are 0 and `viol_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_word | input | 9 | Line word: bit 8 is the command/violation indication, bits 7:0 are the octet or command code |
| line_valid | input | 1 | A line word is present this cycle |
| line_viol | input | 1 | Violation flag, read together with bit 8 |
| viol_clr | input | 1 | Synchronous clear of the violation counter |
| cell_valid | output | 1 | Cell octet present |
| cell_data | output | 8 | Cell octet |
| cell_sop | output | 1 | First octet of a cell |
| cell_eop | output | 1 | 53rd octet of a cell |
| cell_err | output | 1 | One-cycle pulse: the current cell was abandoned |
| viol_count | output | 16 | Saturating violation count |

## Verification
The bench covers violations placed inside a cell. A design that advanced the octet position on them would put the end marker on the wrong octet. It also covers a start-of-cell symbol arriving mid-cell. A design that kept the old count, or stayed silent, would give a misplaced `cell_sop` or a missing `cell_err`. Data sent straight after the 53rd octet shows whether the block really goes back to hunting. The counter is driven past 0xFFFF and is cleared during a violation, which catches wrap-around and clear-priority errors.

// File: rtl/cd_pkg.sv
// Package: shared constants for the cell delineator.
// Assumes: cells are fixed-length; command codes are octet-wide.
package cd_pkg;
    localparam int unsigned CD_CELL_OCTETS = 53;
    localparam logic [7:0]  CD_SOC_CODE    = 8'hC5;
    localparam int unsigned CD_CNT_W       = 16;
endpackage

// File: rtl/cd_classify.sv
// Module: cd_classify
// Splits a 9-bit line word into data, violation, command and start-of-cell.
// Assumes: the violation flag only has meaning when bit 8 is set.
module cd_classify #(
    parameter logic [7:0] SOC_CODE = cd_pkg::CD_SOC_CODE
) (
    input  logic [8:0] word,
    input  logic       valid,
    input  logic       viol,
    output logic       is_data,
    output logic       is_viol,
    output logic       is_cmd,
    output logic       is_soc
);
    // Decode the word kind from the flag bit and violation input.
    always_comb begin
        is_data = valid && !word[8];
        is_viol = valid && word[8] && viol;
        is_cmd  = valid && word[8] && !viol;
        is_soc  = is_cmd && (word[7:0] == SOC_CODE);
    end
endmodule

// File: rtl/cd_framer.sv
// Module: cd_framer
// Hunts for start-of-cell, then streams OCTETS data octets with sop/eop.
// Assumes: violation words are already separated by the classifier.
module cd_framer #(
    parameter int unsigned OCTETS = cd_pkg::CD_CELL_OCTETS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_data,
    input  logic       is_viol,
    input  logic       is_cmd,
    input  logic       is_soc,
    input  logic [7:0] octet,
    output logic       cell_valid,
    output logic [7:0] cell_data,
    output logic       cell_sop,
    output logic       cell_eop,
    output logic       cell_err
);
    localparam int unsigned POS_W = $clog2(OCTETS);
    localparam logic [POS_W-1:0] LAST = POS_W'(OCTETS - 1);

    logic             collecting;
    logic [POS_W-1:0] pos;

    // Track alignment and octet position; register the cell outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collecting <= 1'b0;
            pos        <= '0;
            cell_valid <= 1'b0;
            cell_data  <= '0;
            cell_sop   <= 1'b0;
            cell_eop   <= 1'b0;
            cell_err   <= 1'b0;
        end else begin
            cell_valid <= 1'b0;
            cell_sop   <= 1'b0;
            cell_eop   <= 1'b0;
            cell_err   <= 1'b0;
            if (is_cmd) begin
                cell_err   <= collecting && (pos != '0);
                collecting <= is_soc;
                pos        <= '0;
            end else if (is_data && collecting) begin
                cell_valid <= 1'b1;
                cell_data  <= octet;
                cell_sop   <= (pos == '0);
                cell_eop   <= (pos == LAST);
                if (pos == LAST) begin
                    collecting <= 1'b0;
                    pos        <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    AST_VIOL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        is_viol |=> !cell_valid); // R4
    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!collecting && !is_soc) |=> !cell_valid); // R2
    AST_ERR_NO_OCTET: assert property (@(posedge clk) disable iff (!rst_n)
        cell_err |-> (!cell_valid && !cell_eop)); // R7
    AST_EOP_REHUNT: assert property (@(posedge clk) disable iff (!rst_n)
        cell_eop |-> !collecting); // R6
endmodule

// File: rtl/cd_viol_counter.sv
// Module: cd_viol_counter
// Saturating count of violation words with synchronous clear.
// Assumes: clear wins over a simultaneous increment.
module cd_viol_counter #(
    parameter int unsigned CNT_W = cd_pkg::CD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    // Clear, else increment unless already at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (clr)                   count <= '0;
        else if (inc && count != MAXV)  count <= count + 1'b1;
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R9
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !clr) |=> (count == MAXV)); // R8
    AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && count != MAXV) |=> (count == $past(count) + 1'b1)); // R5
endmodule

// File: rtl/cell_delineator.sv
// Module: cell_delineator
// Top: recovers fixed-length cells from a symbol-delimited parallel line.
// Assumes: one line word per clock at most; outputs lag input by one cycle.
module cell_delineator #(
    parameter int unsigned OCTETS   = cd_pkg::CD_CELL_OCTETS,
    parameter logic [7:0]  SOC_CODE = cd_pkg::CD_SOC_CODE,
    parameter int unsigned CNT_W    = cd_pkg::CD_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [8:0]       line_word,
    input  logic             line_valid,
    input  logic             line_viol,
    input  logic             viol_clr,
    output logic             cell_valid,
    output logic [7:0]       cell_data,
    output logic             cell_sop,
    output logic             cell_eop,
    output logic             cell_err,
    output logic [CNT_W-1:0] viol_count
);
    logic w_data, w_viol, w_cmd, w_soc;

    cd_classify #(.SOC_CODE(SOC_CODE)) u_classify (
        .word(line_word), .valid(line_valid), .viol(line_viol),
        .is_data(w_data), .is_viol(w_viol), .is_cmd(w_cmd), .is_soc(w_soc)
    );

    cd_framer #(.OCTETS(OCTETS)) u_framer (
        .clk(clk), .rst_n(rst_n),
        .is_data(w_data), .is_viol(w_viol), .is_cmd(w_cmd), .is_soc(w_soc),
        .octet(line_word[7:0]),
        .cell_valid(cell_valid), .cell_data(cell_data),
        .cell_sop(cell_sop), .cell_eop(cell_eop), .cell_err(cell_err)
    );

    cd_viol_counter #(.CNT_W(CNT_W)) u_viol_cnt (
        .clk(clk), .rst_n(rst_n), .inc(w_viol), .clr(viol_clr),
        .count(viol_count)
    );
endmodule

// File: tb/test_cell_delineator.sv
module test_cell_delineator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  line_word = '0;
    logic        line_valid = 1'b0;
    logic        line_viol = 1'b0;
    logic        viol_clr = 1'b0;
    logic        cell_valid, cell_sop, cell_eop, cell_err;
    logic [7:0]  cell_data;
    logic [15:0] viol_count;

    int vectors = 0;
    int miscompares = 0;

    localparam logic [7:0] SOC  = 8'hC5;
    localparam logic [7:0] SYNC = 8'h71;

    // reference model state
    bit       m_coll = 0;
    int       m_pos = 0;
    int       m_cnt = 0;
    bit       e_valid, e_sop, e_eop, e_err;
    bit [7:0] e_data;

    always #4 clk = ~clk;

    cell_delineator i_cell_delineator (
        .clk(clk), .rst_n(rst_n), .line_word(line_word), .line_valid(line_valid),
        .line_viol(line_viol), .viol_clr(viol_clr), .cell_valid(cell_valid),
        .cell_data(cell_data), .cell_sop(cell_sop), .cell_eop(cell_eop),
        .cell_err(cell_err), .viol_count(viol_count)
    );

    function automatic bit is_cmd_word(bit v, bit [8:0] w, bit vi);
        return v && w[8] && !vi;
    endfunction

    // Advance the model by one applied word, per the requirements.
    task automatic model(bit v, bit [8:0] w, bit vi, bit clr);
        e_valid = 0; e_sop = 0; e_eop = 0; e_err = 0;
        if (v && w[8] && vi) begin
            if (m_cnt < 65535) m_cnt++;
        end else if (is_cmd_word(v, w, vi)) begin
            e_err = m_coll && (m_pos > 0);
            m_coll = (w[7:0] == SOC);
            m_pos = 0;
        end else if (v && m_coll) begin
            e_valid = 1; e_data = w[7:0];
            e_sop = (m_pos == 0); e_eop = (m_pos == 52);
            m_pos++;
            if (m_pos == 53) begin m_coll = 0; m_pos = 0; end
        end
        if (clr) m_cnt = 0;
    endtask

    task automatic cmp(string tag, string what, int act, int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(bit v, bit [8:0] w, bit vi, bit clr, string tag);
        @(negedge clk);
        line_valid = v; line_word = w; line_viol = vi; viol_clr = clr;
        model(v, w, vi, clr);
        @(posedge clk); #1;
        vectors++;
        cmp(tag, "cell_valid", cell_valid, e_valid);
        if (e_valid) cmp(tag, "cell_data", cell_data, e_data);
        cmp(tag, "cell_sop", cell_sop, e_sop);
        cmp(tag, "cell_eop", cell_eop, e_eop);
        cmp(tag, "cell_err", cell_err, e_err);
        cmp(tag, "viol_count", viol_count, m_cnt);
    endtask

    task automatic data(bit [7:0] d, string tag);  drive(1, {1'b0, d}, $urandom_range(0,1), 0, tag); endtask
    task automatic cmd(bit [7:0] c, string tag);   drive(1, {1'b1, c}, 0, 0, tag); endtask
    task automatic viol(string tag);               drive(1, {1'b1, 8'($urandom)}, 1, 0, tag); endtask

    initial begin
        #1000000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        vectors++;
        cmp("R10", "cell_valid", cell_valid, 0);
        cmp("R10", "cell_err", cell_err, 0);
        cmp("R10", "viol_count", viol_count, 0);

        // R2: hunting ignores data, sync and other commands; R1 idle words
        cmd(SYNC, "R2"); data(8'h11, "R2"); cmd(8'h3A, "R2"); cmd(SYNC, "R2");
        drive(0, {1'b1, SOC}, 0, 0, "R1");
        data(8'h22, "R1");

        // R3/R6: full cell then data beyond eop is not output
        cmd(SOC, "R3");
        for (int i = 0; i < 53; i++) data(8'(i + 8'h40), "R3");
        data(8'hEE, "R6"); data(8'hEF, "R6");

        // R4/R5: violations inside a cell do not advance position
        cmd(SOC, "R4");
        for (int i = 0; i < 53; i++) begin
            if (i % 10 == 3) viol("R4");
            if (i == 20) viol("R5");
            data(8'(i), "R6");
        end

        // R7: mid-cell start-of-cell restarts, mid-cell sync returns to hunt
        cmd(SOC, "R7");
        for (int i = 0; i < 10; i++) data(8'(i), "R7");
        cmd(SOC, "R7");
        for (int i = 0; i < 5; i++) data(8'(i + 1), "R7");
        cmd(SYNC, "R7");
        data(8'h99, "R7");
        cmd(SOC, "R7"); cmd(SOC, "R7");
        for (int i = 0; i < 53; i++) data(8'(255 - i), "R7");

        // random traffic
        for (int c = 0; c < 40; c++) begin
            for (int s = 0; s < int'($urandom_range(0, 3)); s++) cmd(SYNC, "R2");
            cmd(SOC, "R3");
            for (int i = 0; i < 53; i++) begin
                int r = int'($urandom_range(0, 99));
                if (r < 4) viol("R4");
                else if (r < 8) drive(0, 9'($urandom), 0, 0, "R1");
                else if (r == 8) cmd(($urandom_range(0, 1) != 0) ? SOC : SYNC, "R7");
                data(8'($urandom), "R3");
            end
        end

        // R9: clear with a simultaneous violation
        drive(1, 9'h1FF, 1, 1, "R9");
        viol("R5");

        // R8: drive counter past its ceiling
        for (int i = 0; i < 65540; i++) viol("R8");
        cmd(SOC, "R8");
        viol("R8");
        drive(0, 9'h0, 0, 1, "R9");
        viol("R9");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule